// File: doc/BRIEF.md
# Vector Length State CSR Unit

This block keeps the loop-control state that a hardware unrolling loop needs: the maximum vector length (MVL), the active vector length (VL), a 5-bit table configuration selector, and the source and destination element offsets of the element currently in progress. It services write requests aimed at one of three targets (MVL, VL or the packed state word). It returns the value that the requesting instruction should write back, and it flags values that must raise an exception. The stored fields are exposed continuously to the loop sequencer.

Each request is presented for one cycle with `req_valid`. It carries a target select, a value, a flag saying whether the value is an immediate or a register operand, and a flag saying whether the destination register is non-zero. The response (`rsp_valid`, `rsp_wb`, `rsp_data`, `rsp_illegal`) is registered and appears one cycle later. The state registers update on the same clock edge. Lengths use natural values on the MVL and VL targets and minus-one values inside the packed state word. Immediates are also biased by one, so a 5-bit immediate reaches lengths 1 to 32.

The unit has no sequencing beyond that single registered stage. The target select is decoded by a `unique case` over the enumeration MVL, VL, STATE and RESERVED.

Top module: `vlcsr_unit`

## Requirements
- R1: After reset MVL=1, VL=1, configuration=5'b11111 (disabled), both offsets are 0, and `rsp_valid`, `rsp_wb` and `rsp_illegal` are 0.
- R2: A legal write to MVL (target code 0) sets MVL to min(value, XLEN). It clamps VL to the new MVL if VL was larger, and returns the previous MVL.
- R3: A legal write to VL (target code 1) sets VL to min(value, MVL) exactly and returns the new VL, not the old one.
- R4: With `req_imm`=1, an MVL or VL write uses `req_wdata[4:0]`+1 as the value and ignores the upper bits, so immediate 0 requests length 1.
- R5: A register-form (`req_imm`=0) write of 0 to MVL or VL sets `rsp_illegal`, clears `rsp_wb`, and leaves every stored field unchanged.
- R6: A write to STATE (target code 2) returns the previous packed word: MVL-1 in bits 5..0, VL-1 in bits 11..6, source offset in bits 17..12, destination offset in bits 23..18, configuration in bits 28..24, and zeros above.
- R7: A STATE write decodes that same layout in order: MVL = field+1 clamped to 1..XLEN, then VL = field+1 clamped to 1..MVL, then both offsets clamped to 0..VL-1. The configuration is taken as is. In immediate form the word is the zero-extended 5-bit immediate.
- R8: When `req_rd_nz`=0 (destination x0), `rsp_wb` is 0, but the write still updates the stored state.
- R9: An MVL or VL write that changes the value of MVL or VL clears both offsets. One that leaves both unchanged keeps the offsets.
- R10: Target code 3 is reserved. It sets `rsp_illegal`, clears `rsp_wb`, and changes no stored field.
- R11: `rsp_valid` is 1 exactly in the cycle after an accepted request and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_imm | input | 1 | 1: immediate form (value in bits 4..0), 0: register form |
| req_rd_nz | input | 1 | Destination register is not x0 |
| req_tgt | input | 2 | 0 MVL, 1 VL, 2 STATE, 3 reserved |
| req_wdata | input | XLEN | Write value |
| rsp_valid | output | 1 | Response present |
| rsp_wb | output | 1 | Write `rsp_data` back to the destination |
| rsp_illegal | output | 1 | Raise illegal-value exception |
| rsp_data | output | XLEN | Writeback value |
| mvl_o | output | $clog2(XLEN)+1 | Maximum vector length |
| vl_o | output | $clog2(XLEN)+1 | Vector length |
| cfg_o | output | 5 | Table configuration selector |
| srcoffs_o | output | $clog2(XLEN) | Source element offset |
| dstoffs_o | output | $clog2(XLEN) | Destination element offset |

## Verification
Lengths are requested below the current limit, above it, and far above XLEN. This separates exact honouring from clamping, and MVL's old-value return from VL's new-value return. Immediate and register forms are driven with the same numbers and with junk in the upper immediate bits, which exposes a missing bias or a missing mask. Packed state words are written with a VL field above MVL and with offsets beyond VL, which checks the clamp order. Rewrites of unchanged lengths, x0 destinations, zero register values and the reserved target show which side effects stay suppressed.

// File: rtl/vlcsr_pkg.sv
package vlcsr_pkg;
    typedef enum logic [1:0] {
        TGT_MVL   = 2'd0,
        TGT_VL    = 2'd1,
        TGT_STATE = 2'd2,
        TGT_RSVD  = 2'd3
    } tgt_e;

    localparam int PFW = 6;                 // width of each length/offset field in the packed word
    localparam int CFGW = 5;                // configuration selector width
    localparam logic [CFGW-1:0] CFG_OFF = '1;
endpackage

// File: rtl/vlcsr_state_codec.sv
module vlcsr_state_codec
    import vlcsr_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int LW = $clog2(XLEN) + 1,
    localparam int OW = $clog2(XLEN)
) (
    input  logic [LW-1:0]   cur_mvl,
    input  logic [LW-1:0]   cur_vl,
    input  logic [OW-1:0]   cur_src,
    input  logic [OW-1:0]   cur_dst,
    input  logic [CFGW-1:0] cur_cfg,
    input  logic [28:0]     word_in,
    output logic [XLEN-1:0] word_out,
    output logic [LW-1:0]   dec_mvl,
    output logic [LW-1:0]   dec_vl,
    output logic [OW-1:0]   dec_src,
    output logic [OW-1:0]   dec_dst,
    output logic [CFGW-1:0] dec_cfg
);
    logic [LW-1:0] mvl_m1, vl_m1;
    logic [7:0]    m_cl, v_cl, s_cl, d_cl, v_top;

    // pack the present fields, lengths biased down by one
    always_comb begin
        mvl_m1          = cur_mvl - LW'(1);
        vl_m1           = cur_vl - LW'(1);
        word_out        = '0;
        word_out[5:0]   = PFW'(mvl_m1);
        word_out[11:6]  = PFW'(vl_m1);
        word_out[17:12] = PFW'(cur_src);
        word_out[23:18] = PFW'(cur_dst);
        word_out[28:24] = cur_cfg;
    end

    // unpack an incoming word, clamping MVL first, then VL, then offsets
    always_comb begin
        m_cl  = {2'b00, word_in[5:0]} + 8'd1;
        if (m_cl > 8'(XLEN)) m_cl = 8'(XLEN);
        v_cl  = {2'b00, word_in[11:6]} + 8'd1;
        if (v_cl > m_cl) v_cl = m_cl;
        v_top = v_cl - 8'd1;
        s_cl  = {2'b00, word_in[17:12]};
        if (s_cl > v_top) s_cl = v_top;
        d_cl  = {2'b00, word_in[23:18]};
        if (d_cl > v_top) d_cl = v_top;
        dec_mvl = LW'(m_cl);
        dec_vl  = LW'(v_cl);
        dec_src = OW'(s_cl);
        dec_dst = OW'(d_cl);
        dec_cfg = word_in[28:24];
    end
endmodule

// File: rtl/vlcsr_req_eval.sv
module vlcsr_req_eval
    import vlcsr_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int LW = $clog2(XLEN) + 1,
    localparam int OW = $clog2(XLEN)
) (
    input  tgt_e            tgt,
    input  logic            req_imm,
    input  logic            req_rd_nz,
    input  logic [XLEN-1:0] req_wdata,
    input  logic [LW-1:0]   cur_mvl,
    input  logic [LW-1:0]   cur_vl,
    input  logic [OW-1:0]   cur_src,
    input  logic [OW-1:0]   cur_dst,
    input  logic [CFGW-1:0] cur_cfg,
    input  logic [XLEN-1:0] cur_word,
    input  logic [LW-1:0]   dec_mvl,
    input  logic [LW-1:0]   dec_vl,
    input  logic [OW-1:0]   dec_src,
    input  logic [OW-1:0]   dec_dst,
    input  logic [CFGW-1:0] dec_cfg,
    output logic [LW-1:0]   nxt_mvl,
    output logic [LW-1:0]   nxt_vl,
    output logic [OW-1:0]   nxt_src,
    output logic [OW-1:0]   nxt_dst,
    output logic [CFGW-1:0] nxt_cfg,
    output logic [XLEN-1:0] ev_data,
    output logic            ev_wb,
    output logic            ev_illegal
);
    logic [XLEN-1:0] req_len;
    logic            zero_bad;
    logic [LW-1:0]   mvl_cand, vl_cand;

    always_comb begin
        req_len  = req_imm ? (XLEN'(req_wdata[4:0]) + XLEN'(1)) : req_wdata;
        zero_bad = !req_imm && (req_wdata == '0);
        mvl_cand = (req_len > XLEN'(XLEN)) ? LW'(XLEN) : LW'(req_len);
        vl_cand  = (req_len > XLEN'(cur_mvl)) ? cur_mvl : LW'(req_len);
    end

    always_comb begin
        nxt_mvl    = cur_mvl;
        nxt_vl     = cur_vl;
        nxt_src    = cur_src;
        nxt_dst    = cur_dst;
        nxt_cfg    = cur_cfg;
        ev_data    = '0;
        ev_wb      = 1'b0;
        ev_illegal = 1'b0;
        unique case (tgt)
            TGT_MVL: begin
                if (zero_bad) begin
                    ev_illegal = 1'b1;
                end else begin
                    nxt_mvl = mvl_cand;
                    if (cur_vl > mvl_cand) nxt_vl = mvl_cand;
                    ev_data = XLEN'(cur_mvl);
                    ev_wb   = req_rd_nz;
                    if ((nxt_mvl != cur_mvl) || (nxt_vl != cur_vl)) begin
                        nxt_src = '0;
                        nxt_dst = '0;
                    end
                end
            end
            TGT_VL: begin
                if (zero_bad) begin
                    ev_illegal = 1'b1;
                end else begin
                    nxt_vl  = vl_cand;
                    ev_data = XLEN'(vl_cand);
                    ev_wb   = req_rd_nz;
                    if (vl_cand != cur_vl) begin
                        nxt_src = '0;
                        nxt_dst = '0;
                    end
                end
            end
            TGT_STATE: begin
                nxt_mvl = dec_mvl;
                nxt_vl  = dec_vl;
                nxt_src = dec_src;
                nxt_dst = dec_dst;
                nxt_cfg = dec_cfg;
                ev_data = cur_word;
                ev_wb   = req_rd_nz;
            end
            TGT_RSVD: begin
                ev_illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/vlcsr_unit.sv
module vlcsr_unit
    import vlcsr_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int LW = $clog2(XLEN) + 1,
    localparam int OW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_imm,
    input  logic            req_rd_nz,
    input  logic [1:0]      req_tgt,
    input  logic [XLEN-1:0] req_wdata,
    output logic            rsp_valid,
    output logic            rsp_wb,
    output logic            rsp_illegal,
    output logic [XLEN-1:0] rsp_data,
    output logic [LW-1:0]   mvl_o,
    output logic [LW-1:0]   vl_o,
    output logic [4:0]      cfg_o,
    output logic [OW-1:0]   srcoffs_o,
    output logic [OW-1:0]   dstoffs_o
);
    tgt_e            tgt;
    logic [28:0]     word_in;
    logic [XLEN-1:0] cur_word;
    logic [LW-1:0]   dec_mvl, dec_vl, nxt_mvl, nxt_vl;
    logic [OW-1:0]   dec_src, dec_dst, nxt_src, nxt_dst;
    logic [CFGW-1:0] dec_cfg, nxt_cfg;
    logic [XLEN-1:0] ev_data;
    logic            ev_wb, ev_illegal;

    assign tgt     = tgt_e'(req_tgt);
    assign word_in = req_imm ? 29'(req_wdata[4:0]) : req_wdata[28:0];

    vlcsr_state_codec #(.XLEN(XLEN)) codec_i (
        .cur_mvl (mvl_o),
        .cur_vl  (vl_o),
        .cur_src (srcoffs_o),
        .cur_dst (dstoffs_o),
        .cur_cfg (cfg_o),
        .word_in (word_in),
        .word_out(cur_word),
        .dec_mvl (dec_mvl),
        .dec_vl  (dec_vl),
        .dec_src (dec_src),
        .dec_dst (dec_dst),
        .dec_cfg (dec_cfg)
    );

    vlcsr_req_eval #(.XLEN(XLEN)) eval_i (
        .tgt       (tgt),
        .req_imm   (req_imm),
        .req_rd_nz (req_rd_nz),
        .req_wdata (req_wdata),
        .cur_mvl   (mvl_o),
        .cur_vl    (vl_o),
        .cur_src   (srcoffs_o),
        .cur_dst   (dstoffs_o),
        .cur_cfg   (cfg_o),
        .cur_word  (cur_word),
        .dec_mvl   (dec_mvl),
        .dec_vl    (dec_vl),
        .dec_src   (dec_src),
        .dec_dst   (dec_dst),
        .dec_cfg   (dec_cfg),
        .nxt_mvl   (nxt_mvl),
        .nxt_vl    (nxt_vl),
        .nxt_src   (nxt_src),
        .nxt_dst   (nxt_dst),
        .nxt_cfg   (nxt_cfg),
        .ev_data   (ev_data),
        .ev_wb     (ev_wb),
        .ev_illegal(ev_illegal)
    );

    // stored loop state (R1 reset values)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mvl_o     <= LW'(1);
            vl_o      <= LW'(1);
            cfg_o     <= CFG_OFF;
            srcoffs_o <= '0;
            dstoffs_o <= '0;
        end else if (req_valid) begin
            mvl_o     <= nxt_mvl;
            vl_o      <= nxt_vl;
            cfg_o     <= nxt_cfg;
            srcoffs_o <= nxt_src;
            dstoffs_o <= nxt_dst;
        end
    end

    // registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_wb      <= 1'b0;
            rsp_illegal <= 1'b0;
            rsp_data    <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_wb      <= req_valid && ev_wb;
            rsp_illegal <= req_valid && ev_illegal;
            if (req_valid) rsp_data <= ev_data;
        end
    end
endmodule

// File: rtl/vlcsr_unit_chk.sv
module vlcsr_unit_chk #(
    parameter int XLEN = 64,
    localparam int LW = $clog2(XLEN) + 1,
    localparam int OW = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_imm,
    input logic            req_rd_nz,
    input logic [1:0]      req_tgt,
    input logic [XLEN-1:0] req_wdata,
    input logic            rsp_valid,
    input logic            rsp_wb,
    input logic            rsp_illegal,
    input logic [XLEN-1:0] rsp_data,
    input logic [LW-1:0]   mvl_o,
    input logic [LW-1:0]   vl_o,
    input logic [OW-1:0]   srcoffs_o,
    input logic [OW-1:0]   dstoffs_o
);
    logic legal_len;
    assign legal_len = req_imm || (req_wdata != '0);

    AST_MVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mvl_o >= LW'(1)) && (mvl_o <= LW'(XLEN))); // R2
    AST_VL_WITHIN_MVL: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_o >= LW'(1)) && (vl_o <= mvl_o)); // R3
    AST_OFFS_BELOW_VL: assert property (@(posedge clk) disable iff (!rst_n)
        (LW'(srcoffs_o) < vl_o) && (LW'(dstoffs_o) < vl_o)); // R7
    AST_VL_RETURNS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_tgt == 2'd1 && legal_len |=> rsp_data == XLEN'(vl_o)); // R3
    AST_MVL_RETURNS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_tgt == 2'd0 && legal_len |=> rsp_data == XLEN'($past(mvl_o))); // R2
    AST_ZERO_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_tgt[1] == 1'b0 && !legal_len
        |=> rsp_illegal && !rsp_wb && $stable(mvl_o) && $stable(vl_o)); // R5
    AST_X0_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_rd_nz |=> !rsp_wb); // R8
    AST_RSVD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_tgt == 2'd3
        |=> rsp_illegal && $stable(mvl_o) && $stable(vl_o) && $stable(srcoffs_o)); // R10
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid)); // R11
endmodule

bind vlcsr_unit vlcsr_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_imm(req_imm),
    .req_rd_nz(req_rd_nz), .req_tgt(req_tgt), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_wb(rsp_wb), .rsp_illegal(rsp_illegal),
    .rsp_data(rsp_data), .mvl_o(mvl_o), .vl_o(vl_o),
    .srcoffs_o(srcoffs_o), .dstoffs_o(dstoffs_o)
);

// File: tb/vlcsr_unit_tb_top.sv
module vlcsr_unit_tb_top;
    localparam int XLEN = 64;
    localparam int LW = $clog2(XLEN) + 1;
    localparam int OW = $clog2(XLEN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_imm = 1'b0, req_rd_nz = 1'b0;
    logic [1:0] req_tgt = 2'd0;
    logic [XLEN-1:0] req_wdata = '0;
    logic rsp_valid, rsp_wb, rsp_illegal;
    logic [XLEN-1:0] rsp_data;
    logic [LW-1:0] mvl_o, vl_o;
    logic [4:0] cfg_o;
    logic [OW-1:0] srcoffs_o, dstoffs_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vlcsr_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_imm(req_imm),
        .req_rd_nz(req_rd_nz), .req_tgt(req_tgt), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_wb(rsp_wb), .rsp_illegal(rsp_illegal),
        .rsp_data(rsp_data), .mvl_o(mvl_o), .vl_o(vl_o), .cfg_o(cfg_o),
        .srcoffs_o(srcoffs_o), .dstoffs_o(dstoffs_o)
    );

    function automatic logic [63:0] pack(int m, int v, int s, int d, int c);
        return 64'(m - 1) | (64'(v - 1) << 6) | (64'(s) << 12) | (64'(d) << 18) | (64'(c) << 24);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(string tag, int m, int v, int s, int d, int c);
        chk({tag, " mvl"}, 64'(mvl_o), 64'(m));
        chk({tag, " vl"}, 64'(vl_o), 64'(v));
        chk({tag, " src"}, 64'(srcoffs_o), 64'(s));
        chk({tag, " dst"}, 64'(dstoffs_o), 64'(d));
        chk({tag, " cfg"}, 64'(cfg_o), 64'(c));
    endtask

    // drive at negedge, response sampled at the following negedge
    task automatic req(int tgt, bit imm, bit rdnz, logic [63:0] val);
        req_tgt = 2'(tgt); req_imm = imm; req_rd_nz = rdnz; req_wdata = val;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_state(int m, int v, int s, int d, int c);
        req(2, 1'b0, 1'b1, pack(m, v, s, d, c));
    endtask

    task automatic t_reset;
        chk_state("R1 reset", 1, 1, 0, 0, 31);
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        chk("R1 rsp_illegal", 64'(rsp_illegal), 0);
    endtask

    task automatic t_mvl;
        req(0, 1'b0, 1'b1, 64'd8);
        chk("R2 old mvl returned", rsp_data, 1);
        chk("R2 mvl set", 64'(mvl_o), 8);
        chk("R2 wb", 64'(rsp_wb), 1);
        chk("R11 rsp_valid", 64'(rsp_valid), 1);
        req(0, 1'b0, 1'b1, 64'd100);
        chk("R2 old mvl 8", rsp_data, 8);
        chk("R2 mvl clamp XLEN", 64'(mvl_o), 64);
        req(0, 1'b1, 1'b1, 64'd3);
        chk("R4 imm mvl", 64'(mvl_o), 4);
        chk("R4 imm old mvl", rsp_data, 64);
        set_state(8, 6, 0, 0, 0);
        req(0, 1'b0, 1'b1, 64'd3);
        chk("R2 vl follows mvl", 64'(vl_o), 3);
        chk("R2 mvl 3", 64'(mvl_o), 3);
        chk("R2 returns 8", rsp_data, 8);
    endtask

    task automatic t_vl;
        set_state(4, 1, 0, 0, 0);
        req(1, 1'b0, 1'b1, 64'd3);
        chk("R3 vl exact", 64'(vl_o), 3);
        chk("R3 new vl returned", rsp_data, 3);
        req(1, 1'b0, 1'b1, 64'd50);
        chk("R3 vl clamp", 64'(vl_o), 4);
        chk("R3 clamp returned", rsp_data, 4);
        req(1, 1'b1, 1'b1, 64'd0);
        chk("R4 imm zero -> 1", 64'(vl_o), 1);
        chk("R4 imm zero returned", rsp_data, 1);
        chk("R4 imm zero legal", 64'(rsp_illegal), 0);
        req(1, 1'b1, 1'b1, 64'hFFE2);
        chk("R4 upper imm bits ignored", 64'(vl_o), 3);
    endtask

    task automatic t_zero;
        set_state(5, 3, 1, 2, 4);
        req(0, 1'b0, 1'b1, 64'd0);
        chk("R5 mvl zero illegal", 64'(rsp_illegal), 1);
        chk("R5 mvl zero no wb", 64'(rsp_wb), 0);
        chk_state("R5 mvl zero", 5, 3, 1, 2, 4);
        req(1, 1'b0, 1'b1, 64'd0);
        chk("R5 vl zero illegal", 64'(rsp_illegal), 1);
        chk_state("R5 vl zero", 5, 3, 1, 2, 4);
    endtask

    task automatic t_state;
        set_state(2, 1, 0, 0, 0);
        req(2, 1'b0, 1'b1, 64'd9 | (64'd5 << 6) | (64'd3 << 12) | (64'd7 << 18) | (64'd2 << 24));
        chk("R6 old word", rsp_data, pack(2, 1, 0, 0, 0));
        chk_state("R7 dst clamp", 10, 6, 3, 5, 2);
        req(2, 1'b0, 1'b1, 64'd3 | (64'd10 << 6) | (64'd9 << 12) | (64'd31 << 24));
        chk("R6 packed layout", rsp_data, pack(10, 6, 3, 5, 2));
        chk_state("R7 vl and src clamp", 4, 4, 3, 0, 31);
        req(2, 1'b1, 1'b1, 64'd7);
        chk("R6 before imm", rsp_data, pack(4, 4, 3, 0, 31));
        chk_state("R7 imm state", 8, 1, 0, 0, 0);
    endtask

    task automatic t_offs;
        set_state(8, 4, 2, 1, 0);
        req(1, 1'b0, 1'b1, 64'd4);
        chk_state("R9 same vl keeps offs", 8, 4, 2, 1, 0);
        req(1, 1'b0, 1'b1, 64'd3);
        chk_state("R9 vl change clears", 8, 3, 0, 0, 0);
        set_state(8, 4, 2, 1, 0);
        req(0, 1'b0, 1'b1, 64'd8);
        chk_state("R9 same mvl keeps offs", 8, 4, 2, 1, 0);
        req(0, 1'b0, 1'b1, 64'd6);
        chk_state("R9 mvl change clears", 6, 4, 0, 0, 0);
    endtask

    task automatic t_x0;
        set_state(8, 1, 0, 0, 0);
        req(1, 1'b0, 1'b0, 64'd2);
        chk("R8 vl x0 no wb", 64'(rsp_wb), 0);
        chk("R8 vl still set", 64'(vl_o), 2);
        chk("R8 rsp_valid", 64'(rsp_valid), 1);
        req(0, 1'b0, 1'b0, 64'd5);
        chk("R8 mvl x0 no wb", 64'(rsp_wb), 0);
        chk("R8 mvl still set", 64'(mvl_o), 5);
    endtask

    task automatic t_rsvd;
        set_state(6, 2, 1, 1, 3);
        req(3, 1'b0, 1'b1, 64'd9);
        chk("R10 illegal", 64'(rsp_illegal), 1);
        chk("R10 no wb", 64'(rsp_wb), 0);
        chk_state("R10 unchanged", 6, 2, 1, 1, 3);
    endtask

    task automatic t_timing;
        req(1, 1'b0, 1'b1, 64'd1);
        chk("R11 valid after req", 64'(rsp_valid), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R11 valid drops", 64'(rsp_valid), 0);
        chk("R11 wb drops", 64'(rsp_wb), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_mvl;
        t_vl;
        t_zero;
        t_state;
        t_offs;
        t_x0;
        t_rsvd;
        t_timing;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule